// File: doc/BRIEF.md
# Control-Transfer Sequencer for an 8-bit CPU

This block carries out the branch, call and return group of an 8-bit accumulator processor that has a 16-bit program counter and a 16-bit stack pointer. It owns PC, SP, the loop counter register B and the two interrupt-enable flags. It is started with an already decoded operation code, a condition bit, a restart vector and a 16-bit register-pair value. It then reads operand bytes and stack bytes, and writes return addresses, through a byte-wide memory port. The memory answers a read in the same cycle it is addressed.

Every bus access takes one clock and every internal cycle takes one clock. When an operation finishes, `done` pulses for one clock and `cycles` holds the number of clocks spent after the start was accepted. Operations that need neither the bus nor a delay take one clock. Decoding the opcode, arithmetic and accepting interrupts are handled elsewhere.

Top module: `xfer_seq`

## Requirements
- R1: After reset PC is 0x0000, SP is 0xFFFF, B is 0, both interrupt-enable flags are 0, and `done` and `cycles` are 0.
- R2: A push writes the high byte of the value to SP-1, then writes the low byte to SP-2, and leaves SP lowered by 2.
- R3: A pop reads the low byte at SP, then reads the high byte at SP+1, and leaves SP raised by 2.
- R4: Call (code 1 uses `cond`, code 2 is unconditional) always reads the low and then the high target byte at PC, leaving PC advanced by 2. A false condition ends after 2 cycles with no write. Otherwise one internal cycle follows, the advanced PC is pushed and PC takes the target, for 5 cycles in total.
- R5: Conditional return (code 3) spends one internal cycle and then ends when `cond` is 0, for 1 cycle. When `cond` is 1 it pops PC, for 3 cycles. Unconditional return (code 4) takes 3 cycles and pops PC.
- R6: Restart (code 5) spends one internal cycle, pushes PC and loads PC with `vector`×8, for 3 cycles.
- R7: Loop (code 0) spends one internal cycle, reads a signed displacement at PC, advances PC by 1 and decrements B. If B is now 0 it ends after 2 cycles. Otherwise it adds the sign-extended displacement to PC modulo 2^16 and spends 5 more cycles, for 7 in total.
- R8: Return-from-NMI (code 7) pops PC and copies the second enable flag into the first. The other interrupt return (code 8) pops PC and leaves both flags alone. Each takes 2 cycles.
- R9: Disable (code 9) clears both enable flags and enable (code 10) sets both, each in 1 cycle.
- R10: Code 6 loads PC from `pair` in 1 cycle. Code 11 loads SP from `pair` in 2 cycles. Code 12 loads B from `pair[15:8]` in 1 cycle. Codes 13 to 15 change nothing and take 1 cycle.
- R11: `done` is high for exactly one clock per accepted start. A start raised while an operation is in progress is ignored. The memory port never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the operation on `op` (accepted only when idle) |
| op | input | 4 | Decoded operation code |
| cond | input | 1 | Condition outcome for the conditional forms |
| vector | input | 3 | Restart vector number |
| pair | input | 16 | Register-pair value for jump, SP load and B load |
| mem_rdata | input | 8 | Read data, valid in the cycle the address is presented |
| mem_addr | output | 16 | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| b | output | 8 | Loop counter register |
| iff1 | output | 1 | First interrupt-enable flag |
| iff2 | output | 1 | Second interrupt-enable flag |
| done | output | 1 | One-clock end-of-operation pulse |
| cycles | output | 4 | Clock count of the last finished operation |

## Verification
The loop is run with a negative displacement, a positive one, a final pass that reaches zero, and a displacement that carries PC across 0xFFFF. Together these separate the decrement from the branch decision and show whether the offset is sign-extended and wraps. Calls and returns are tried with the condition both false and true. The two paths differ in cycle count, in stack writes and in the final PC, and the stack bytes left in memory show the order of the high and low bytes. Call/return pairs and restart/return pairs are nested in sequence, so a wrong SP step or a swapped pop order shows up as a wrong return address. A start raised during a long loop pass confirms that the busy sequencer ignores it.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [3:0] {
        OP_LOOP   = 4'd0,
        OP_CALLC  = 4'd1,
        OP_CALL   = 4'd2,
        OP_RETC   = 4'd3,
        OP_RET    = 4'd4,
        OP_RST    = 4'd5,
        OP_JPPAIR = 4'd6,
        OP_RETNMI = 4'd7,
        OP_RETINT = 4'd8,
        OP_DI     = 4'd9,
        OP_EI     = 4'd10,
        OP_LDSP   = 4'd11,
        OP_LDB    = 4'd12
    } xfer_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_DISP,
        ST_SPIN,
        ST_FLO,
        ST_FHI,
        ST_PUSHH,
        ST_PUSHL,
        ST_POPL,
        ST_POPH,
        ST_APPLY
    } seq_state_e;

endpackage

// File: rtl/xfer_rel_add.sv
module xfer_rel_add #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] sum
);
    localparam int EXT = AW - DW;

    logic [AW-1:0] disp_ext;

    generate
        if (EXT > 0) begin : g_ext
            assign disp_ext = {{EXT{disp[DW-1]}}, disp};
        end else begin : g_noext
            assign disp_ext = disp[AW-1:0];
        end
    endgenerate

    assign sum = base + disp_ext;
endmodule

// File: rtl/xfer_cycle_meter.sv
module xfer_cycle_meter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy,
    input  logic             fin,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] run_d, run_q;
    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        run_d   = run_q;
        count_d = count_q;
        if (fin) begin
            count_d = run_q + CNT_W'(1);
            run_d   = '0;
        end else if (busy) begin
            run_d = run_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            count_q <= '0;
        end else begin
            run_q   <= run_d;
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CNT_W      = 4,
    parameter int TAKEN_WAIT = 5,
    parameter int LDSP_WAIT  = 2,
    parameter logic [2*DW-1:0] RESET_PC = '0,
    parameter logic [2*DW-1:0] RESET_SP = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic            cond,
    input  logic [2:0]      vector,
    input  logic [2*DW-1:0] pair,
    input  logic [DW-1:0]   mem_rdata,
    output logic [2*DW-1:0] mem_addr,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [DW-1:0]   mem_wdata,
    output logic [2*DW-1:0] pc,
    output logic [2*DW-1:0] sp,
    output logic [DW-1:0]   b,
    output logic            iff1,
    output logic            iff2,
    output logic            done,
    output logic [CNT_W-1:0] cycles
);
    localparam int AW       = 2 * DW;
    localparam int SPIN_MAX = (TAKEN_WAIT > LDSP_WAIT) ? TAKEN_WAIT : LDSP_WAIT;
    localparam int SPIN_W   = $clog2(SPIN_MAX + 1);
    localparam logic [SPIN_W-1:0] TAKEN_SPIN = SPIN_W'(TAKEN_WAIT - 1);
    localparam logic [SPIN_W-1:0] LDSP_SPIN  = SPIN_W'(LDSP_WAIT - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [3:0]        op;
        logic              cond;
        logic [2:0]        vec;
        logic [AW-1:0]     pair;
        logic [AW-1:0]     pc;
        logic [AW-1:0]     sp;
        logic [DW-1:0]     b;
        logic              iff1;
        logic              iff2;
        logic [AW-1:0]     tgt;
        logic [SPIN_W-1:0] spin;
        logic              done;
    } seq_s;

    localparam seq_s RESET_S = '{
        state: ST_IDLE, op: '0, cond: 1'b0, vec: '0, pair: '0,
        pc: RESET_PC, sp: RESET_SP, b: '0, iff1: 1'b0, iff2: 1'b0,
        tgt: '0, spin: '0, done: 1'b0
    };

    seq_s s_d, s_q;
    logic fin;
    logic [AW-1:0] pc_inc, sp_dec, sp_inc, loop_tgt;
    logic [DW-1:0] b_dec;

    assign pc_inc = s_q.pc + AW'(1);
    assign sp_dec = s_q.sp - AW'(1);
    assign sp_inc = s_q.sp + AW'(1);
    assign b_dec  = s_q.b - DW'(1);

    xfer_rel_add #(.AW(AW), .DW(DW)) u_rel (
        .base (pc_inc),
        .disp (mem_rdata),
        .sum  (loop_tgt)
    );

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        fin       = 1'b0;
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;

        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.op   = op;
                    s_d.cond = cond;
                    s_d.vec  = vector;
                    s_d.pair = pair;
                    unique case (op)
                        OP_LOOP, OP_RETC, OP_RET, OP_RST: s_d.state = ST_PRE;
                        OP_CALLC, OP_CALL:                s_d.state = ST_FLO;
                        OP_RETNMI, OP_RETINT:             s_d.state = ST_POPL;
                        OP_LDSP: begin
                            s_d.spin  = LDSP_SPIN;
                            s_d.state = ST_SPIN;
                        end
                        default:                          s_d.state = ST_APPLY;
                    endcase
                end
            end

            ST_PRE: begin
                unique case (s_q.op)
                    OP_LOOP: s_d.state = ST_DISP;
                    OP_RET:  s_d.state = ST_POPL;
                    OP_RETC: begin
                        if (s_q.cond) begin
                            s_d.state = ST_POPL;
                        end else begin
                            s_d.state = ST_IDLE;
                            s_d.done  = 1'b1;
                            fin       = 1'b1;
                        end
                    end
                    OP_RST: begin
                        s_d.tgt   = AW'(s_q.vec) << 3;
                        s_d.state = ST_PUSHH;
                    end
                    default: s_d.state = ST_PUSHH;
                endcase
            end

            ST_DISP: begin
                mem_rd   = 1'b1;
                mem_addr = s_q.pc;
                s_d.b    = b_dec;
                if (b_dec == '0) begin
                    s_d.pc    = pc_inc;
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    fin       = 1'b1;
                end else begin
                    s_d.pc    = loop_tgt;
                    s_d.spin  = TAKEN_SPIN;
                    s_d.state = ST_SPIN;
                end
            end

            ST_SPIN: begin
                if (s_q.spin == '0) begin
                    if (s_q.op == OP_LDSP) begin
                        s_d.sp = s_q.pair;
                    end
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    fin       = 1'b1;
                end else begin
                    s_d.spin = s_q.spin - SPIN_W'(1);
                end
            end

            ST_FLO: begin
                mem_rd          = 1'b1;
                mem_addr        = s_q.pc;
                s_d.pc          = pc_inc;
                s_d.tgt[DW-1:0] = mem_rdata;
                s_d.state       = ST_FHI;
            end

            ST_FHI: begin
                mem_rd            = 1'b1;
                mem_addr          = s_q.pc;
                s_d.pc            = pc_inc;
                s_d.tgt[AW-1:DW]  = mem_rdata;
                if (s_q.op == OP_CALL || s_q.cond) begin
                    s_d.state = ST_PRE;
                end else begin
                    s_d.state = ST_IDLE;
                    s_d.done  = 1'b1;
                    fin       = 1'b1;
                end
            end

            ST_PUSHH: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = s_q.pc[AW-1:DW];
                s_d.sp    = sp_dec;
                s_d.state = ST_PUSHL;
            end

            ST_PUSHL: begin
                mem_wr    = 1'b1;
                mem_addr  = sp_dec;
                mem_wdata = s_q.pc[DW-1:0];
                s_d.sp    = sp_dec;
                s_d.pc    = s_q.tgt;
                s_d.state = ST_IDLE;
                s_d.done  = 1'b1;
                fin       = 1'b1;
            end

            ST_POPL: begin
                mem_rd          = 1'b1;
                mem_addr        = s_q.sp;
                s_d.tgt[DW-1:0] = mem_rdata;
                s_d.sp          = sp_inc;
                s_d.state       = ST_POPH;
            end

            ST_POPH: begin
                mem_rd    = 1'b1;
                mem_addr  = s_q.sp;
                s_d.pc    = {mem_rdata, s_q.tgt[DW-1:0]};
                s_d.sp    = sp_inc;
                if (s_q.op == OP_RETNMI) begin
                    s_d.iff1 = s_q.iff2;
                end
                s_d.state = ST_IDLE;
                s_d.done  = 1'b1;
                fin       = 1'b1;
            end

            ST_APPLY: begin
                unique case (s_q.op)
                    OP_JPPAIR: s_d.pc = s_q.pair;
                    OP_LDB:    s_d.b  = s_q.pair[AW-1:DW];
                    OP_DI: begin
                        s_d.iff1 = 1'b0;
                        s_d.iff2 = 1'b0;
                    end
                    OP_EI: begin
                        s_d.iff1 = 1'b1;
                        s_d.iff2 = 1'b1;
                    end
                    default: ;
                endcase
                s_d.state = ST_IDLE;
                s_d.done  = 1'b1;
                fin       = 1'b1;
            end

            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= RESET_S;
        end else begin
            s_q <= s_d;
        end
    end

    xfer_cycle_meter #(.CNT_W(CNT_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (s_q.state != ST_IDLE),
        .fin   (fin),
        .count (cycles)
    );

    assign pc   = s_q.pc;
    assign sp   = s_q.sp;
    assign b    = s_q.b;
    assign iff1 = s_q.iff1;
    assign iff2 = s_q.iff2;
    assign done = s_q.done;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk
    import xfer_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CNT_W      = 4,
    parameter int TAKEN_WAIT = 5
) (
    input logic             clk,
    input logic             rst_n,
    input seq_state_e       st,
    input logic [3:0]       op_q,
    input logic             cond_q,
    input logic             done,
    input logic [CNT_W-1:0] cycles,
    input logic [DW-1:0]    b,
    input logic [2*DW-1:0]  sp,
    input logic             iff1,
    input logic             iff2,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic [2*DW-1:0]  mem_addr
);
    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> sp == $past(sp) - 16'd1);

    // R3
    pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_POPL || st == ST_POPH) |-> (mem_rd && mem_addr == sp));

    // R4
    call_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_CALLC) |-> cycles == (cond_q ? CNT_W'(5) : CNT_W'(2)));

    // R7
    loop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_LOOP) |->
            cycles == ((b == '0) ? CNT_W'(2) : CNT_W'(2 + TAKEN_WAIT)));

    // R8
    iff_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iff1 != $past(iff1)) |-> done);

    // R9
    ei_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_q == OP_EI) |-> (iff1 && iff2));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
endmodule

bind xfer_seq xfer_seq_chk #(.DW(DW), .CNT_W(CNT_W), .TAKEN_WAIT(TAKEN_WAIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (s_q.state),
    .op_q     (s_q.op),
    .cond_q   (s_q.cond),
    .done     (done),
    .cycles   (cycles),
    .b        (b),
    .sp       (sp),
    .iff1     (iff1),
    .iff2     (iff2),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr)
);

// File: tb/xfer_seq_bench.sv
module xfer_seq_bench;
    import xfer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n, start, cond;
    logic [3:0]  op;
    logic [2:0]  vector;
    logic [15:0] pair;
    logic [7:0]  mem_rdata, mem_wdata, b;
    logic [15:0] mem_addr, pc, sp;
    logic        mem_rd, mem_wr, iff1, iff2, done;
    logic [3:0]  cycles;

    always #4 clk = ~clk;

    xfer_seq u_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cond(cond),
        .vector(vector), .pair(pair), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .pc(pc), .sp(sp), .b(b), .iff1(iff1),
        .iff2(iff2), .done(done), .cycles(cycles)
    );

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

    typedef struct {
        string       req;
        logic [3:0]  cyc;
        logic [15:0] pc, sp;
        logic [7:0]  b;
        logic        i1, i2;
    } exp_t;

    exp_t exp_q[$];
    int compared = 0;
    int mismatched = 0;

    logic [15:0] m_pc = 16'h0000, m_sp = 16'hFFFF;
    logic [7:0]  m_b = 8'h00;
    logic        m_i1 = 1'b0, m_i2 = 1'b0;

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design reports completion
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check("R11", "unexpected done", 16'd1, 16'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "cycles", 16'(cycles), 16'(e.cyc));
                check(e.req, "pc", pc, e.pc);
                check(e.req, "sp", sp, e.sp);
                check(e.req, "b", 16'(b), 16'(e.b));
                check(e.req, "iff1", 16'(iff1), 16'(e.i1));
                check(e.req, "iff2", 16'(iff2), 16'(e.i2));
            end
        end
    end

    // Model one operation; returns whether a push happened and its value
    task automatic model(input logic [3:0] o, input logic c, input logic [2:0] v,
                         input logic [15:0] p, output int n,
                         output logic pushed, output logic [15:0] pval);
        logic [7:0]  d;
        logic [15:0] t;
        n = 1;
        pushed = 1'b0;
        pval = '0;
        case (o)
            OP_LOOP: begin
                d = mem[m_pc[11:0]];
                m_pc = m_pc + 16'd1;
                m_b = m_b - 8'd1;
                n = 2;
                if (m_b != 8'd0) begin
                    n = 7;
                    m_pc = m_pc + {{8{d[7]}}, d};
                end
            end
            OP_CALLC, OP_CALL: begin
                t = {mem[12'(m_pc + 16'd1)], mem[m_pc[11:0]]};
                m_pc = m_pc + 16'd2;
                n = 2;
                if (o == OP_CALL || c) begin
                    n = 5; pushed = 1'b1; pval = m_pc;
                    m_sp = m_sp - 16'd2; m_pc = t;
                end
            end
            OP_RETC, OP_RET: begin
                n = 1;
                if (o == OP_RET || c) begin
                    n = 3;
                    m_pc = {mem[12'(m_sp + 16'd1)], mem[m_sp[11:0]]};
                    m_sp = m_sp + 16'd2;
                end
            end
            OP_RST: begin
                n = 3; pushed = 1'b1; pval = m_pc;
                m_sp = m_sp - 16'd2; m_pc = 16'(v) * 16'd8;
            end
            OP_RETNMI, OP_RETINT: begin
                n = 2;
                m_pc = {mem[12'(m_sp + 16'd1)], mem[m_sp[11:0]]};
                m_sp = m_sp + 16'd2;
                if (o == OP_RETNMI) m_i1 = m_i2;
            end
            OP_JPPAIR: m_pc = p;
            OP_LDB:    m_b = p[15:8];
            OP_DI:     begin m_i1 = 1'b0; m_i2 = 1'b0; end
            OP_EI:     begin m_i1 = 1'b1; m_i2 = 1'b1; end
            OP_LDSP:   begin n = 2; m_sp = p; end
            default: ;
        endcase
    endtask

    // Driver: pushes the expected item, starts the block, waits for completion
    task automatic issue(input logic [3:0] o, input logic c, input logic [2:0] v,
                         input logic [15:0] p, input string req);
        int n;
        logic pushed;
        logic [15:0] pval;
        exp_t e;
        model(o, c, v, p, n, pushed, pval);
        e.req = req; e.cyc = 4'(n); e.pc = m_pc; e.sp = m_sp;
        e.b = m_b; e.i1 = m_i1; e.i2 = m_i2;
        exp_q.push_back(e);
        @(negedge clk);
        start = 1'b1; op = o; cond = c; vector = v; pair = p;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        if (pushed) begin
            // R2: high byte at the upper address, low byte at the new SP
            check("R2", "stack high", 16'(mem[12'(m_sp + 16'd1)]), 16'(pval[15:8]));
            check("R2", "stack low", 16'(mem[m_sp[11:0]]), 16'(pval[7:0]));
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("WATCHDOG", "timeout", 16'd1, 16'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        mem[12'h100] = 8'hFE;  mem[12'h0FF] = 8'h10;  mem[12'hFFE] = 8'h7F;
        mem[12'h200] = 8'h34;  mem[12'h201] = 8'h12;
        mem[12'h202] = 8'h78;  mem[12'h203] = 8'h05;
        mem[12'h204] = 8'h00;  mem[12'h205] = 8'h03;
        mem[12'hEFF] = 8'hAA;  mem[12'hEFE] = 8'hAA;
        rst_n = 1'b0; start = 1'b0; op = '0; cond = 1'b0; vector = '0; pair = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1", "pc", pc, 16'h0000);
        check("R1", "sp", sp, 16'hFFFF);
        check("R1", "b", 16'(b), 16'h0000);
        check("R1", "iff", 16'({iff1, iff2}), 16'h0000);
        check("R1", "done", 16'(done), 16'h0000);
        check("R1", "cycles", 16'(cycles), 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);

        issue(OP_LDSP,   1'b0, 3'd0, 16'h0F00, "R10");
        issue(OP_JPPAIR, 1'b0, 3'd0, 16'h0100, "R10");
        issue(OP_LDB,    1'b0, 3'd0, 16'h0300, "R10");
        issue(OP_LOOP,   1'b0, 3'd0, 16'h0000, "R7");   // backward branch
        issue(OP_LOOP,   1'b0, 3'd0, 16'h0000, "R7");   // forward branch
        issue(OP_LOOP,   1'b0, 3'd0, 16'h0000, "R7");   // B reaches zero
        issue(OP_LDB,    1'b0, 3'd0, 16'h0200, "R10");
        issue(OP_JPPAIR, 1'b0, 3'd0, 16'hFFFE, "R10");
        issue(OP_LOOP,   1'b0, 3'd0, 16'h0000, "R7");   // wraps past 0xFFFF
        issue(OP_JPPAIR, 1'b0, 3'd0, 16'h0200, "R10");
        issue(OP_CALLC,  1'b0, 3'd0, 16'h0000, "R4");   // not taken
        check("R4", "no stack write", 16'({mem[12'hEFF], mem[12'hEFE]}), 16'hAAAA);
        issue(OP_CALLC,  1'b1, 3'd0, 16'h0000, "R4");   // taken
        issue(OP_RETC,   1'b0, 3'd0, 16'h0000, "R5");
        issue(OP_RETC,   1'b1, 3'd0, 16'h0000, "R3");
        issue(OP_RST,    1'b0, 3'd5, 16'h0000, "R6");
        issue(OP_RET,    1'b0, 3'd0, 16'h0000, "R5");
        issue(OP_EI,     1'b0, 3'd0, 16'h0000, "R9");
        issue(OP_DI,     1'b0, 3'd0, 16'h0000, "R9");
        issue(OP_EI,     1'b0, 3'd0, 16'h0000, "R9");
        issue(OP_CALL,   1'b0, 3'd0, 16'h0000, "R4");
        issue(OP_RETINT, 1'b0, 3'd0, 16'h0000, "R8");
        issue(OP_RST,    1'b0, 3'd7, 16'h0000, "R6");
        issue(OP_DI,     1'b0, 3'd0, 16'h0000, "R9");
        issue(OP_RETNMI, 1'b0, 3'd0, 16'h0000, "R8");
        issue(4'd15,     1'b1, 3'd7, 16'hFFFF, "R10");  // unassigned code

        // R11: a start during a long loop pass is ignored
        issue(OP_LDB, 1'b0, 3'd0, 16'h0500, "R10");
        begin
            int n;
            logic pushed;
            logic [15:0] pval;
            exp_t e;
            model(OP_LOOP, 1'b0, 3'd0, 16'h0000, n, pushed, pval);
            e.req = "R11"; e.cyc = 4'(n); e.pc = m_pc; e.sp = m_sp;
            e.b = m_b; e.i1 = m_i1; e.i2 = m_i2;
            exp_q.push_back(e);
            @(negedge clk);
            start = 1'b1; op = OP_LOOP;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1; op = OP_EI;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            repeat (12) @(negedge clk);
            check("R11", "iff after ignored start", 16'({iff1, iff2}), 16'h0000);
            check("R11", "scoreboard drained", 16'(exp_q.size()), 16'd0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule